// File: doc/BRIEF.md
# Fragment-Coded Page Table Entry Range Writer

This block turns one request to fill a run of page table entries into a stream of 64-bit entry words, one per cycle. A request carries a start index, an exclusive end index, the page frame number that the first entry maps, a 12-bit flag field, and a size-mode bit. Each output entry maps one 4KB page. The frame number goes up by one for every emitted entry, so the run covers one physically contiguous range.

When a run is mapped to local memory and is valid, the block finds the largest sub-range whose bounds fall on the selected fragment alignment. It tags every entry in that sub-range with a large-page fragment code. The unaligned entries before and after it keep the plain 4KB code. A run that maps system memory, is marked invalid, or has no aligned interior is emitted with plain entries throughout.

The control is a five-state machine:
- `ST_IDLE` waits for a request.
- `ST_HEAD`, `ST_MID` and `ST_TAIL` emit the leading plain entries, the fragment-coded middle entries and the trailing plain entries.
- `ST_FINISH` raises a one-cycle completion pulse.

Transitions:
- On acceptance, `ST_IDLE` goes to the state of the first region, or to `ST_FINISH` for an empty run.
- Each accepted entry moves to the state of the region holding the next index, or to `ST_FINISH` after the last entry.
- `ST_FINISH` always returns to `ST_IDLE`.

Top module: `pte_frag_writer`

## Requirements
- R1: Each entry word holds the page frame number zero-extended in bits 63:12 and the 12-bit flag field in bits 11:0. In the flag field, bit 0 is valid, bit 1 is system memory, bit 5 is readable, bit 6 is writeable, and bits 9:7 are the fragment code (0 = 4KB).
- R2: For a request (start, end, pfn), the block emits exactly one entry for each index from start to end-1, in ascending order. The entry for index start+k carries frame number pfn+k.
- R3: With `req_big`=1, the alignment is 64 entries and the fragment code is 6. With `req_big`=0, the alignment is 16 entries and the fragment code is 4.
- R4: Let the aligned start be start rounded up to the alignment and the aligned end be end rounded down to it. When neither fallback condition of R5 holds, entries with index in [aligned start, aligned end) carry flags OR (code << 7). All other entries carry the flags unchanged.
- R5: If flag bit 1 is set, or flag bit 0 is clear, or the aligned start is not below the aligned end, every entry carries the flags unchanged. In that case bits 9:7 stay as given.
- R6: A request with end <= start emits no entry. It raises `done` in the cycle right after acceptance.
- R7: `done` is high for exactly one cycle. For a non-empty run, that is the cycle right after the last entry is accepted.
- R8: `req_ready` is high only in the idle state. It stays low from acceptance through the `done` cycle and is high again the cycle after `done`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_idx` and `out_entry` hold their values.
- R10: After reset, `req_ready`=1, `out_valid`=0 and `done`=0, including when reset arrives in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_start | input | IDX_W | First entry index of the run |
| req_end | input | IDX_W | Exclusive end entry index |
| req_pfn | input | PFN_W | Frame number for the first entry |
| req_flags | input | 12 | Mapping flags |
| req_big | input | 1 | 1 = 256KB fragments, 0 = 64KB fragments |
| out_valid | output | 1 | Entry word available |
| out_ready | input | 1 | Downstream takes the entry |
| out_idx | output | IDX_W | Index of the current entry |
| out_entry | output | 64 | Entry word |
| done | output | 1 | One-cycle run completion pulse |

## Verification
The bench uses the following runs, each chosen to expose a specific fault:
- **Head, middle and tail present in one run, in both modes.** A design with a rounding error would shift the coded window by one alignment step. One with the wrong mode decode would place the window at the other granularity.
- **Runs that start or end exactly on a boundary.** These expose off-by-one heads and tails.
- **Runs whose aligned interior is empty.** These catch a design that codes a zero-width or negative window.
- **System-memory and invalid runs.** These show whether the fallback is ignored, which would leave fragment codes on entries that must stay plain.
- **Empty and reversed runs.** These catch a missing or late `done`, or spurious entries.
- **Backpressure on several runs.** This reveals a frame number or index that advances while stalled.

// File: rtl/pte_frag_pkg.sv
package pte_frag_pkg;

    localparam int FLAG_W    = 12;
    localparam int FRAG_LSB  = 7;
    localparam int FRAG_W    = 3;
    localparam int ENTRY_W   = 64;
    localparam int PAGE_LSB  = 12;
    localparam int BIT_VALID = 0;
    localparam int BIT_SYS   = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEAD,
        ST_MID,
        ST_TAIL,
        ST_FINISH
    } wr_state_e;

endpackage

// File: rtl/pte_run_planner.sv
module pte_run_planner
    import pte_frag_pkg::*;
#(
    parameter int IDX_W      = 16,
    parameter int SMALL_LOG2 = 4,
    parameter int LARGE_LOG2 = 6,
    parameter logic [FRAG_W-1:0] SMALL_CODE = 3'd4,
    parameter logic [FRAG_W-1:0] LARGE_CODE = 3'd6
) (
    input  logic [IDX_W-1:0]  run_start,
    input  logic [IDX_W-1:0]  run_end,
    input  logic              flag_valid,
    input  logic              flag_sys,
    input  logic              big_mode,
    output logic [IDX_W-1:0]  mid_lo,
    output logic [IDX_W-1:0]  mid_hi,
    output logic [FRAG_W-1:0] frag_code,
    output wr_state_e         first_state
);

    localparam int XW = IDX_W + 1;
    localparam logic [XW-1:0] SMALL_MASK = XW'((64'd1 << SMALL_LOG2) - 64'd1);
    localparam logic [XW-1:0] LARGE_MASK = XW'((64'd1 << LARGE_LOG2) - 64'd1);

    logic [XW-1:0] start_x;
    logic [XW-1:0] end_x;
    logic [XW-1:0] mask;
    logic [XW-1:0] up_start;
    logic [XW-1:0] dn_end;
    logic          frag_ok;
    logic          empty_run;

    always_comb begin
        start_x   = {1'b0, run_start};
        end_x     = {1'b0, run_end};
        mask      = big_mode ? LARGE_MASK : SMALL_MASK;
        frag_code = big_mode ? LARGE_CODE : SMALL_CODE;
        up_start  = (start_x + mask) & ~mask;
        dn_end    = end_x & ~mask;
        empty_run = (run_end <= run_start);
        frag_ok   = flag_valid && !flag_sys && (up_start < dn_end);
        if (frag_ok) begin
            mid_lo = up_start[IDX_W-1:0];
            mid_hi = dn_end[IDX_W-1:0];
        end else begin
            mid_lo = run_end;
            mid_hi = run_end;
        end
        if (empty_run) begin
            first_state = ST_FINISH;
        end else if (run_start < mid_lo) begin
            first_state = ST_HEAD;
        end else if (run_start < mid_hi) begin
            first_state = ST_MID;
        end else begin
            first_state = ST_TAIL;
        end
    end

endmodule

// File: rtl/pte_entry_gen.sv
module pte_entry_gen
    import pte_frag_pkg::*;
#(
    parameter int PFN_W = 36
) (
    input  logic [PFN_W-1:0]   pfn,
    input  logic [FLAG_W-1:0]  flags,
    input  logic [FRAG_W-1:0]  code,
    input  logic               use_code,
    output logic [ENTRY_W-1:0] word
);

    localparam int PAD_W = ENTRY_W - PAGE_LSB - PFN_W;

    logic [FLAG_W-1:0] low_bits;

    always_comb begin
        low_bits = flags;
        if (use_code) begin
            low_bits = flags | (FLAG_W'(code) << FRAG_LSB);
        end
        word = {{PAD_W{1'b0}}, pfn, low_bits};
    end

endmodule

// File: rtl/pte_frag_writer.sv
module pte_frag_writer
    import pte_frag_pkg::*;
#(
    parameter int IDX_W      = 16,
    parameter int PFN_W      = 36,
    parameter int SMALL_LOG2 = 4,
    parameter int LARGE_LOG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IDX_W-1:0]   req_start,
    input  logic [IDX_W-1:0]   req_end,
    input  logic [PFN_W-1:0]   req_pfn,
    input  logic [11:0]        req_flags,
    input  logic               req_big,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [IDX_W-1:0]   out_idx,
    output logic [63:0]        out_entry,
    output logic               done
);

    localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);
    localparam logic [PFN_W-1:0] PFN_ONE = PFN_W'(1);

    wr_state_e         state;
    wr_state_e         state_nxt;
    wr_state_e         plan_first;
    logic [IDX_W-1:0]  idx_r;
    logic [IDX_W-1:0]  end_r;
    logic [IDX_W-1:0]  lo_r;
    logic [IDX_W-1:0]  hi_r;
    logic [PFN_W-1:0]  pfn_r;
    logic [FLAG_W-1:0] flags_r;
    logic [FRAG_W-1:0] code_r;
    logic [IDX_W-1:0]  plan_lo;
    logic [IDX_W-1:0]  plan_hi;
    logic [FRAG_W-1:0] plan_code;
    logic [IDX_W-1:0]  idx_inc;
    logic              accept;
    logic              fire;
    logic              in_mid;

    pte_run_planner #(
        .IDX_W      (IDX_W),
        .SMALL_LOG2 (SMALL_LOG2),
        .LARGE_LOG2 (LARGE_LOG2)
    ) u_plan (
        .run_start   (req_start),
        .run_end     (req_end),
        .flag_valid  (req_flags[BIT_VALID]),
        .flag_sys    (req_flags[BIT_SYS]),
        .big_mode    (req_big),
        .mid_lo      (plan_lo),
        .mid_hi      (plan_hi),
        .frag_code   (plan_code),
        .first_state (plan_first)
    );

    pte_entry_gen #(
        .PFN_W (PFN_W)
    ) u_gen (
        .pfn      (pfn_r),
        .flags    (flags_r),
        .code     (code_r),
        .use_code (in_mid),
        .word     (out_entry)
    );

    // Output decode from state
    always_comb begin
        req_ready = 1'b0;
        out_valid = 1'b0;
        done      = 1'b0;
        in_mid    = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_HEAD:   out_valid = 1'b1;
            ST_MID: begin
                out_valid = 1'b1;
                in_mid    = 1'b1;
            end
            ST_TAIL:   out_valid = 1'b1;
            ST_FINISH: done      = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign out_idx = idx_r;
    assign accept  = req_valid && req_ready;
    assign fire    = out_valid && out_ready;
    assign idx_inc = idx_r + IDX_ONE;

    // Next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    state_nxt = plan_first;
                end
            end
            ST_HEAD, ST_MID, ST_TAIL: begin
                if (fire) begin
                    if (idx_inc == end_r) begin
                        state_nxt = ST_FINISH;
                    end else if (idx_inc < lo_r) begin
                        state_nxt = ST_HEAD;
                    end else if (idx_inc < hi_r) begin
                        state_nxt = ST_MID;
                    end else begin
                        state_nxt = ST_TAIL;
                    end
                end
            end
            ST_FINISH: state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Run context and walking position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_r   <= '0;
            end_r   <= '0;
            lo_r    <= '0;
            hi_r    <= '0;
            pfn_r   <= '0;
            flags_r <= '0;
            code_r  <= '0;
        end else if (accept) begin
            idx_r   <= req_start;
            end_r   <= req_end;
            lo_r    <= plan_lo;
            hi_r    <= plan_hi;
            pfn_r   <= req_pfn;
            flags_r <= req_flags;
            code_r  <= plan_code;
        end else if (fire) begin
            idx_r <= idx_inc;
            pfn_r <= pfn_r + PFN_ONE;
        end
    end

    // R8
    ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (out_valid || done)));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_idx) && $stable(out_entry)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (done || (out_valid && out_idx == $past(out_idx) + IDX_ONE)));

    // R2
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_idx < end_r));

    // R5
    frag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && in_mid) |-> (out_entry[BIT_VALID] && !out_entry[BIT_SYS]));

endmodule

// File: tb/pte_frag_writer_test.sv
module pte_frag_writer_test;

    localparam int CLK_P = 10;
    localparam int IW    = 16;
    localparam int PW    = 36;
    localparam int NVEC  = 11;

    typedef struct packed {
        logic [15:0] s;
        logic [15:0] e;
        logic [11:0] fl;
        logic        big;
        logic        stall;
        logic [15:0] nh;
        logic [15:0] nm;
        logic [15:0] nt;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{16'd3,   16'd40,  12'h061, 1'b0, 1'b0, 16'd13, 16'd16,  16'd8},
        '{16'd16,  16'd48,  12'h061, 1'b0, 1'b1, 16'd0,  16'd32,  16'd0},
        '{16'd5,   16'd20,  12'h061, 1'b0, 1'b0, 16'd15, 16'd0,   16'd0},
        '{16'd10,  16'd200, 12'h061, 1'b1, 1'b1, 16'd54, 16'd128, 16'd8},
        '{16'd3,   16'd40,  12'h063, 1'b0, 1'b0, 16'd37, 16'd0,   16'd0},
        '{16'd3,   16'd40,  12'h060, 1'b0, 1'b1, 16'd37, 16'd0,   16'd0},
        '{16'd0,   16'd64,  12'h021, 1'b1, 1'b0, 16'd0,  16'd64,  16'd0},
        '{16'd7,   16'd8,   12'h041, 1'b0, 1'b0, 16'd1,  16'd0,   16'd0},
        '{16'd30,  16'd30,  12'h061, 1'b0, 1'b0, 16'd0,  16'd0,   16'd0},
        '{16'd50,  16'd40,  12'h061, 1'b1, 1'b0, 16'd0,  16'd0,   16'd0},
        '{16'd100, 16'd130, 12'h061, 1'b1, 1'b0, 16'd30, 16'd0,   16'd0}
    };

    logic          clk;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [IW-1:0] req_start;
    logic [IW-1:0] req_end;
    logic [PW-1:0] req_pfn;
    logic [11:0]   req_flags;
    logic          req_big;
    logic          out_valid;
    logic          out_ready;
    logic [IW-1:0] out_idx;
    logic [63:0]   out_entry;
    logic          done;

    int total_checks = 0;
    int bad_checks   = 0;
    bit finished     = 0;

    pte_frag_writer #(.IDX_W(IW), .PFN_W(PW)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_start (req_start),
        .req_end   (req_end),
        .req_pfn   (req_pfn),
        .req_flags (req_flags),
        .req_big   (req_big),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_idx   (out_idx),
        .out_entry (out_entry),
        .done      (done)
    );

    initial clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input logic [PW-1:0] base);
        int got = 0;
        int total = int'(v.nh) + int'(v.nm) + int'(v.nt);
        int cyc = 0;
        bit prev_last = 0;
        bit seen_done = 0;
        bit held = 0;
        logic [IW-1:0] h_idx = '0;
        logic [63:0] h_ent = '0;
        logic [2:0] code = v.big ? 3'd6 : 3'd4;
        @(negedge clk);
        req_start = v.s;
        req_end   = v.e;
        req_pfn   = base;
        req_flags = v.fl;
        req_big   = v.big;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!seen_done && cyc < 2000) begin
            out_ready = v.stall ? ((cyc % 3) != 2) : 1'b1;
            #1;
            if (held) begin
                // R9 values held across stall
                chk(out_valid && out_idx == h_idx && out_entry == h_ent, "R9 stall hold",
                    out_entry, h_ent);
                held = 0;
            end
            if (done) begin
                // R2 entry count, R6/R7 done timing
                chk(got == total, "R2 entry count", 64'(got), 64'(total));
                if (total == 0) begin
                    chk(cyc == 0, "R6 done right after accept", 64'(cyc), 64'd0);
                end else begin
                    chk(prev_last, "R7 done after last entry", 64'(prev_last), 64'd1);
                end
                chk(!out_valid, "R7 no entry with done", 64'(out_valid), 64'd0);
                seen_done = 1;
            end else if (out_valid) begin
                prev_last = 0;
                // R8 busy while emitting
                chk(!req_ready, "R8 ready low while busy", 64'(req_ready), 64'd0);
                if (out_ready) begin
                    logic cod;
                    logic [63:0] exp;
                    cod = (got >= int'(v.nh)) && (got < int'(v.nh) + int'(v.nm));
                    exp = (64'(base + PW'(got)) << 12) |
                          64'(v.fl | (cod ? (12'(code) << 7) : 12'h000));
                    // R1 R3 R4 R5 entry contents
                    chk(out_entry == exp, "R4 entry word", out_entry, exp);
                    // R2 index order
                    chk(out_idx == v.s + IW'(got), "R2 entry index", 64'(out_idx), 64'(v.s + IW'(got)));
                    got++;
                    prev_last = (got == total);
                end else begin
                    held  = 1;
                    h_idx = out_idx;
                    h_ent = out_entry;
                end
            end else begin
                prev_last = 0;
            end
            cyc++;
            @(negedge clk);
        end
        chk(seen_done, "R7 done seen", 64'(seen_done), 64'd1);
        #1;
        chk(req_ready && !done, "R8 ready after done", 64'(req_ready), 64'd1);
        out_ready = 1'b1;
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_start = '0;
        req_end   = '0;
        req_pfn   = '0;
        req_flags = '0;
        req_big   = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk(req_ready, "R10 ready in reset", 64'(req_ready), 64'd1);
        chk(!out_valid, "R10 no entry in reset", 64'(out_valid), 64'd0);
        chk(!done, "R10 no done in reset", 64'(done), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i], PW'(36'h1000 + 36'(i) * 36'h100));
        end

        // R1 high frame bits land at top of word
        run_vec('{16'd8, 16'd10, 12'h061, 1'b0, 1'b0, 16'd2, 16'd0, 16'd0}, 36'hF_FFFF_FFF0);

        // R10 reset in the middle of a run
        @(negedge clk);
        req_start = 16'd0;
        req_end   = 16'd100;
        req_pfn   = 36'h77;
        req_flags = 12'h061;
        req_big   = 1'b0;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk(out_valid, "R10 run active before reset", 64'(out_valid), 64'd1);
        rst_n = 1'b0;
        #1;
        chk(!out_valid && req_ready && !done, "R10 idle after mid-run reset",
            {61'd0, out_valid, req_ready, done}, 64'b010);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!out_valid && req_ready, "R10 stays idle after release",
            {62'd0, out_valid, req_ready}, 64'b01);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            finished = 1;
            total_checks++;
            bad_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
            $finish;
        end
    end

endmodule